// File: doc/BRIEF.md
# Block-Lock Write Permission Unit

This block is the write-permission gate of a serial nonvolatile memory. It decides, one request at a time, whether a data-array write or a status-register write may proceed. Its inputs are the command strobes that a serial command decoder produces, a protect pin and the write-in-progress flag of the nonvolatile sequencer. Its outputs are two grant pulses and the status byte that the decoder shifts out on a status read.

Three stored items control the decisions. The first is a write enable latch, which must be armed before any write request. The second is a two-bit lock code that protects none, the uppermost quarter, the uppermost half or the whole of the address space. The third is a pin-enable bit. When that bit is set, a low level on the protect pin refuses status-register writes. An accepted status write is held as pending. The new lock code and pin-enable take effect when the write-in-progress flag falls. A change on the protect pin during that interval does not cancel the write.

A synthesis parameter can move the protected region to the bottom of the address space. The defaults model a 13-bit (8 KiB) array.

Top module: `wrperm_unit`

## Requirements
- R1: After reset the status byte reads 0x00 while the write-in-progress input is low, and neither grant is high.
- R2: A set strobe arms the write enable latch (status bit 1). A clear strobe disarms it. When both strobes come in one cycle, the clear strobe wins.
- R3: No array or status write is granted unless the latch was armed in the cycle of the request.
- R4: The lock code sits in status bits 3:2. Code 00 locks nothing. Code 01 locks addresses at or above 3/4 of the space (0x1800 and up with 13 bits). Code 10 locks addresses at or above 1/2 (0x1000 and up). Code 11 locks every address. An array write to a locked address is dropped.
- R5: Every array or status write request disarms the latch, whether it is granted or not. This holds even when a set strobe comes in the same cycle.
- R6: When the pin-enable bit (status bit 7) is 1 and the protect pin is low, status writes are refused. When the pin is high, they are granted.
- R7: When the pin-enable bit is 0, the protect pin has no effect on status writes.
- R8: An accepted status write loads its lock code and pin-enable into status bits 3:2 and 7 only at the first clock edge at which the write-in-progress input is low after having been high. The protect pin falling in between does not cancel it.
- R9: A write request is refused while the write-in-progress input is high or while an accepted status write is still pending.
- R10: When a status write and an array write are requested in the same cycle, only the status write is considered. The array write is refused.
- R11: Status layout: bit 0 follows the write-in-progress input, bit 1 is the latch, bits 3:2 are the lock code, bit 7 is pin-enable, and bits 6:4 read 0.
- R12: A grant is a single-cycle pulse in the cycle after the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wel_set_i | input | 1 | Arm the write enable latch |
| wel_clr_i | input | 1 | Disarm the write enable latch |
| sr_wr_i | input | 1 | Status-register write request |
| sr_bp_i | input | 2 | Requested lock code |
| sr_wpen_i | input | 1 | Requested pin-enable value |
| arr_wr_i | input | 1 | Array write request |
| arr_addr_i | input | ADDR_W | Array write address |
| lock_n_i | input | 1 | Protect pin, low = protect |
| busy_i | input | 1 | Write-in-progress flag from the sequencer |
| arr_grant_o | output | 1 | Array write granted (pulse) |
| sr_grant_o | output | 1 | Status write granted (pulse) |
| status_o | output | 8 | Status byte |

## Verification
The collisions that matter are a latch strobe arriving together with a write request, and a status request arriving together with an array request. The bench drives a set strobe and a write request in the same cycle. It expects the decision to use the old latch value and the latch to end disarmed. It drives both write strobes together and expects only the status grant. A cycle-accurate behavioural model in the bench judges every clock edge, so each collision is checked against the model as well as by explicit expected values.

// File: rtl/wrperm_pkg.sv
package wrperm_pkg;
   localparam int ST_W      = 8;
   localparam int ST_BUSY   = 0;
   localparam int ST_WEL    = 1;
   localparam int ST_BP_LSB = 2;
   localparam int ST_WPEN   = 7;

   typedef enum logic [1:0] {
      LOCK_NONE = 2'b00,
      LOCK_QTR  = 2'b01,
      LOCK_HALF = 2'b10,
      LOCK_ALL  = 2'b11
   } lock_code_e;

   typedef struct packed {
      logic       wpen;
      lock_code_e bp;
   } nv_fields_t;

   function automatic logic [ST_W-1:0] pack_status(input nv_fields_t f,
                                                   input logic wel,
                                                   input logic busy);
      logic [ST_W-1:0] s;
      s                  = '0;
      s[ST_BUSY]         = busy;
      s[ST_WEL]          = wel;
      s[ST_BP_LSB +: 2]  = f.bp;
      s[ST_WPEN]         = f.wpen;
      return s;
   endfunction
endpackage

// File: rtl/wrperm_region.sv
module wrperm_region
   import wrperm_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter bit FROM_TOP = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  lock_code_e        code_i,
   output logic              locked_o
);
   localparam logic [ADDR_W-1:0] QTR_SPAN  = ADDR_W'(1) << (ADDR_W-2);
   localparam logic [ADDR_W-1:0] HALF_SPAN = ADDR_W'(1) << (ADDR_W-1);

   logic in_qtr;
   logic in_half;

   generate
      if (FROM_TOP) begin : g_top
         assign in_qtr  = addr_i >= (HALF_SPAN + QTR_SPAN);
         assign in_half = addr_i >= HALF_SPAN;
      end else begin : g_bottom
         assign in_qtr  = addr_i < QTR_SPAN;
         assign in_half = addr_i < HALF_SPAN;
      end
   endgenerate

   always_comb begin
      unique case (code_i)
         LOCK_NONE: locked_o = 1'b0;
         LOCK_QTR:  locked_o = in_qtr;
         LOCK_HALF: locked_o = in_half;
         LOCK_ALL:  locked_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/wrperm_wel.sv
module wrperm_wel (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic consume_i,
   output logic wel_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_o <= 1'b0;
      end else if (clr_i || consume_i) begin
         wel_o <= 1'b0;
      end else if (set_i) begin
         wel_o <= 1'b1;
      end
   end
endmodule

// File: rtl/wrperm_srgate.sv
module wrperm_srgate
   import wrperm_pkg::*;
#(
   parameter logic [1:0] RST_BP   = 2'b00,
   parameter bit         RST_WPEN = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       try_i,
   input  logic       lock_n_i,
   input  logic       busy_i,
   input  nv_fields_t wdata_i,
   output logic       accept_o,
   output logic       pend_o,
   output nv_fields_t fields_o
);
   localparam nv_fields_t RST_FIELDS = '{wpen: RST_WPEN, bp: lock_code_e'(RST_BP)};

   nv_fields_t fields_q;
   nv_fields_t stage_q;
   logic       pend_q;
   logic       busy_q;
   logic       pin_bar;
   logic       commit;

   assign pin_bar  = fields_q.wpen & ~lock_n_i;
   assign accept_o = try_i & ~pin_bar;
   assign commit   = pend_q & busy_q & ~busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fields_q <= RST_FIELDS;
         stage_q  <= RST_FIELDS;
         pend_q   <= 1'b0;
         busy_q   <= 1'b0;
      end else begin
         busy_q <= busy_i;
         if (accept_o) begin
            pend_q  <= 1'b1;
            stage_q <= wdata_i;
         end else if (commit) begin
            pend_q   <= 1'b0;
            fields_q <= stage_q;
         end
      end
   end

   assign pend_o   = pend_q;
   assign fields_o = fields_q;
endmodule

// File: rtl/wrperm_unit.sv
module wrperm_unit
   import wrperm_pkg::*;
#(
   parameter int         ADDR_W        = 13,
   parameter bit         LOCK_FROM_TOP = 1'b1,
   parameter logic [1:0] RST_BP        = 2'b00,
   parameter bit         RST_WPEN      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wel_set_i,
   input  logic              wel_clr_i,
   input  logic              sr_wr_i,
   input  logic [1:0]        sr_bp_i,
   input  logic              sr_wpen_i,
   input  logic              arr_wr_i,
   input  logic [ADDR_W-1:0] arr_addr_i,
   input  logic              lock_n_i,
   input  logic              busy_i,
   output logic              arr_grant_o,
   output logic              sr_grant_o,
   output logic [7:0]        status_o
);
   generate
      if (ADDR_W < 2) begin : g_bad_aw
         $error("wrperm_unit: ADDR_W must be at least 2");
      end
      if (ST_W != 8) begin : g_bad_st
         $error("wrperm_unit: status byte must be 8 bits");
      end
   endgenerate

   logic       wel;
   logic       pend;
   logic       locked;
   logic       idle;
   logic       sr_try;
   logic       sr_accept;
   logic       arr_accept;
   logic       consume;
   nv_fields_t fields;
   nv_fields_t wdata;

   assign wdata      = '{wpen: sr_wpen_i, bp: lock_code_e'(sr_bp_i)};
   assign idle       = ~busy_i & ~pend;
   assign sr_try     = sr_wr_i & wel & idle;
   assign arr_accept = arr_wr_i & ~sr_wr_i & wel & idle & ~locked;
   assign consume    = sr_wr_i | arr_wr_i;

   wrperm_wel u_wel (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (wel_set_i),
      .clr_i     (wel_clr_i),
      .consume_i (consume),
      .wel_o     (wel)
   );

   wrperm_region #(
      .ADDR_W   (ADDR_W),
      .FROM_TOP (LOCK_FROM_TOP)
   ) u_region (
      .addr_i   (arr_addr_i),
      .code_i   (fields.bp),
      .locked_o (locked)
   );

   wrperm_srgate #(
      .RST_BP   (RST_BP),
      .RST_WPEN (RST_WPEN)
   ) u_srgate (
      .clk      (clk),
      .rst_n    (rst_n),
      .try_i    (sr_try),
      .lock_n_i (lock_n_i),
      .busy_i   (busy_i),
      .wdata_i  (wdata),
      .accept_o (sr_accept),
      .pend_o   (pend),
      .fields_o (fields)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arr_grant_o <= 1'b0;
         sr_grant_o  <= 1'b0;
      end else begin
         arr_grant_o <= arr_accept;
         sr_grant_o  <= sr_accept;
      end
   end

   assign status_o = pack_status(fields, wel, busy_i);
endmodule

// File: rtl/wrperm_chk.sv
module wrperm_chk #(
   parameter int ADDR_W        = 13,
   parameter bit LOCK_FROM_TOP = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sr_wr_i,
   input logic              arr_wr_i,
   input logic [ADDR_W-1:0] arr_addr_i,
   input logic              lock_n_i,
   input logic              busy_i,
   input logic              arr_grant_o,
   input logic              sr_grant_o,
   input logic              st_wel,
   input logic [1:0]        st_bp,
   input logic              st_wpen
);
   localparam logic [ADDR_W-1:0] QTR_EDGE = ADDR_W'(3) << (ADDR_W-2);

   p_arr_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      arr_grant_o |-> $past(st_wel));
   p_sr_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sr_grant_o |-> $past(st_wel));
   p_all_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr_i && st_bp == 2'b11) |=> !arr_grant_o);

   generate
      if (LOCK_FROM_TOP) begin : g_top
         p_top_qtr_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (arr_wr_i && st_bp != 2'b00 && arr_addr_i >= QTR_EDGE) |=> !arr_grant_o);
      end
   endgenerate

   p_request_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr_i || sr_wr_i) |=> !st_wel);
   p_pin_refuses_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_i && !lock_n_i && st_wpen) |=> !sr_grant_o);
   p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable({st_wpen, st_bp}));
   p_busy_refuses_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> !(arr_grant_o || sr_grant_o));
   p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(arr_grant_o && sr_grant_o));
   p_sr_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      sr_grant_o |=> !sr_grant_o);
   p_arr_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      arr_grant_o |=> !arr_grant_o);
endmodule

bind wrperm_unit wrperm_chk #(
   .ADDR_W        (ADDR_W),
   .LOCK_FROM_TOP (LOCK_FROM_TOP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sr_wr_i     (sr_wr_i),
   .arr_wr_i    (arr_wr_i),
   .arr_addr_i  (arr_addr_i),
   .lock_n_i    (lock_n_i),
   .busy_i      (busy_i),
   .arr_grant_o (arr_grant_o),
   .sr_grant_o  (sr_grant_o),
   .st_wel      (status_o[1]),
   .st_bp       (status_o[3:2]),
   .st_wpen     (status_o[7])
);

// File: tb/wrperm_unit_bench.sv
module wrperm_unit_bench;
   localparam int AW = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wel_set_i = 1'b0;
   logic          wel_clr_i = 1'b0;
   logic          sr_wr_i = 1'b0;
   logic [1:0]    sr_bp_i = 2'b00;
   logic          sr_wpen_i = 1'b0;
   logic          arr_wr_i = 1'b0;
   logic [AW-1:0] arr_addr_i = '0;
   logic          lock_n_i = 1'b1;
   logic          busy_i = 1'b0;
   logic          arr_grant_o;
   logic          sr_grant_o;
   logic [7:0]    status_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   wrperm_unit #(.ADDR_W(AW)) u_wrperm_unit (
      .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i),
      .sr_wr_i(sr_wr_i), .sr_bp_i(sr_bp_i), .sr_wpen_i(sr_wpen_i),
      .arr_wr_i(arr_wr_i), .arr_addr_i(arr_addr_i), .lock_n_i(lock_n_i),
      .busy_i(busy_i), .arr_grant_o(arr_grant_o), .sr_grant_o(sr_grant_o),
      .status_o(status_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
      end
   endtask

   // behavioural reference model
   int m_wel = 0, m_bp = 0, m_wpen = 0, m_busy_prev = 0, m_ag = 0, m_sg = 0;
   int pend_q[$];

   function automatic int is_locked(input int a, input int code);
      case (code)
         0:       return 0;
         1:       return (a >= ((1 << AW) * 3) / 4) ? 1 : 0;
         2:       return (a >= (1 << AW) / 2) ? 1 : 0;
         default: return 1;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wel = 0; m_bp = 0; m_wpen = 0; m_busy_prev = 0; m_ag = 0; m_sg = 0;
         pend_q.delete();
      end else begin
         int blocked;
         int commit;
         blocked = (busy_i || pend_q.size() > 0) ? 1 : 0;
         commit  = (pend_q.size() > 0 && m_busy_prev == 1 && !busy_i) ? 1 : 0;
         m_ag = 0;
         m_sg = 0;
         if (sr_wr_i) begin
            if (m_wel == 1 && blocked == 0 && !(m_wpen == 1 && !lock_n_i)) begin
               m_sg = 1;
               pend_q.push_back(int'(sr_wpen_i) * 4 + int'(sr_bp_i));
            end
         end else if (arr_wr_i) begin
            if (m_wel == 1 && blocked == 0 && is_locked(int'(arr_addr_i), m_bp) == 0)
               m_ag = 1;
         end
         if (commit == 1) begin
            int v;
            v = pend_q.pop_front();
            m_bp   = v % 4;
            m_wpen = v / 4;
         end
         if (sr_wr_i || arr_wr_i || wel_clr_i) m_wel = 0;
         else if (wel_set_i) m_wel = 1;
         m_busy_prev = busy_i ? 1 : 0;
      end
   end

   always @(posedge clk) begin
      #3;
      if (rst_n) begin
         chk("R11 model status", int'(status_o), m_wpen * 128 + m_bp * 4 + m_wel * 2 + int'(busy_i));
         chk("R4 model array grant", int'(arr_grant_o), m_ag);
         chk("R6 model status grant", int'(sr_grant_o), m_sg);
      end
   end

   task automatic cmd(input bit set, input bit clr, input bit sw, input int bp,
                      input bit wp, input bit aw, input int addr);
      wel_set_i  = set;
      wel_clr_i  = clr;
      sr_wr_i    = sw;
      sr_bp_i    = 2'(bp);
      sr_wpen_i  = wp;
      arr_wr_i   = aw;
      arr_addr_i = AW'(addr);
      @(posedge clk); #1;
      wel_set_i = 1'b0; wel_clr_i = 1'b0; sr_wr_i = 1'b0; arr_wr_i = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask
   task automatic arm();
      cmd(1, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic arr(input int addr);
      cmd(0, 0, 0, 0, 0, 1, addr);
   endtask
   task automatic srw(input int bp, input bit wp);
      cmd(0, 0, 1, bp, wp, 0, 0);
   endtask
   task automatic nv_cycle(input int n);
      busy_i = 1'b1;
      repeat (n) tick();
      busy_i = 1'b0;
      tick();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #2_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1 reset status", int'(status_o), 0);
      chk("R1 reset array grant", int'(arr_grant_o), 0);
      chk("R1 reset status grant", int'(sr_grant_o), 0);

      arm();
      chk("R2 latch set", int'(status_o), 'h02);
      cmd(1, 1, 0, 0, 0, 0, 0);
      chk("R2 clear beats set", int'(status_o), 'h00);

      arr(0);
      chk("R3 unarmed array write", int'(arr_grant_o), 0);
      cmd(1, 0, 0, 0, 0, 1, 0);
      chk("R5 set with write uses old latch", int'(arr_grant_o), 0);
      chk("R5 set with write ends disarmed", int'(status_o), 'h00);

      arm(); arr(0);
      chk("R12 array grant pulse", int'(arr_grant_o), 1);
      chk("R5 latch cleared after grant", int'(status_o), 'h00);
      tick();
      chk("R12 grant drops", int'(arr_grant_o), 0);

      lock_n_i = 1'b0;
      arm(); srw(1, 0);
      chk("R7 pin ignored when disabled", int'(sr_grant_o), 1);
      chk("R8 fields unchanged while pending", int'(status_o), 'h00);
      arm(); arr(0);
      chk("R9 pending refuses array write", int'(arr_grant_o), 0);
      busy_i = 1'b1;
      tick();
      chk("R11 busy bit", int'(status_o), 'h01);
      busy_i = 1'b0;
      tick();
      chk("R8 commit at busy fall", int'(status_o), 'h04);
      lock_n_i = 1'b1;

      arm(); arr(6144);
      chk("R4 quarter lock refuses 0x1800", int'(arr_grant_o), 0);
      arm(); arr(6143);
      chk("R4 quarter lock allows 0x17FF", int'(arr_grant_o), 1);

      arm(); srw(2, 0); nv_cycle(2);
      chk("R8 half code committed", int'(status_o), 'h08);
      arm(); arr(4096);
      chk("R4 half lock refuses 0x1000", int'(arr_grant_o), 0);
      arm(); arr(4095);
      chk("R4 half lock allows 0x0FFF", int'(arr_grant_o), 1);

      arm(); cmd(0, 0, 1, 3, 1, 1, 0);
      chk("R10 status wins", int'(sr_grant_o), 1);
      chk("R10 array refused", int'(arr_grant_o), 0);
      lock_n_i = 1'b0;
      nv_cycle(3);
      chk("R8 pin fall does not cancel", int'(status_o), 'h8C);

      arm(); srw(0, 0);
      chk("R6 pin low with enable refuses", int'(sr_grant_o), 0);
      chk("R5 refused write disarms", int'(status_o), 'h8C);
      arm(); arr(0);
      chk("R4 full lock refuses address 0", int'(arr_grant_o), 0);

      lock_n_i = 1'b1;
      arm(); srw(0, 0);
      chk("R6 pin high grants", int'(sr_grant_o), 1);
      nv_cycle(1);
      chk("R6 fields cleared after commit", int'(status_o), 'h00);

      busy_i = 1'b1;
      arm(); arr(0);
      chk("R9 busy refuses array write", int'(arr_grant_o), 0);
      busy_i = 1'b0;
      tick(); tick();
      finish_run();
   end
endmodule